// File: doc/BRIEF.md
# OTP Code-Memory Programming Port

This block is the programming and verify access path of a small one-time-programmable code memory. Its reset input does two jobs. Held high long enough, it resets the access path. After that reset is released, the same pin carries a serial unlock key, one bit per oscillator clock, sent least significant bit first. A matching key puts the block into its programming state. Any other key returns it to normal operation.

In the programming state, an 11-bit address is built from one 8-bit address port. An address-select input decides whether the port is loading the low byte or the 3-bit high part. A mode input picks the access type:
- **Verify:** the addressed byte is driven on the data output, with its output enable raised.
- **Program:** a write strobe burns the data-input byte into the addressed location. Programming can only clear bits. The stored word becomes the bitwise AND of the old contents and the new byte. The erased value is all ones.

The array is modelled as a plain 2K x 8 register array. Voltages and pulse timing are not modelled.

Top module: `otp_prog_port`

## Requirements
- R1: A reset needs `rst_pin` sampled high on RST_HOLD (default 24) consecutive clock edges. At that edge the block leaves the programming state, clears both address parts to 0, and `prog_active` and `data_oe` read 0. A high run shorter than RST_HOLD has no effect.
- R2: After a reset, the first edge that samples `rst_pin` low starts key capture. The next 10 edges sample the key bits in order, bit 0 first. If the 10 bits equal KEY (default 10'h2D3), `prog_active` becomes 1 at the tenth key edge, and not before.
- R3: A 10-bit key that differs from KEY leaves `prog_active` at 0. Further serial bits are ignored until the next reset.
- R4: In the programming state, each clock edge with `addr_sel`=0 loads `addr_port` into the low address byte. Each edge with `addr_sel`=1 loads `addr_port[2:0]` into the high part, and `addr_port[7:3]` is ignored. The array address is {high[2:0], low[7:0]}.
- R5: With `prog_active`=1 and `mode_verify`=1, `data_oe` is 1 and `data_out` equals the byte stored at the latched address. This holds combinationally in the same cycle the address or mode changes.
- R6: Whenever `data_oe` is 0, `data_out` is 8'h00. `data_oe` is 0 whenever `mode_verify`=0 or `prog_active`=0.
- R7: Every location reads 8'hFF before it is written. A clock edge with `prog_active`=1, `mode_verify`=0 and `wr_strobe`=1 replaces the addressed byte with (old AND `data_in`), so bits can only go from 1 to 0.
- R8: `wr_strobe` changes no location while `mode_verify`=1 or while `prog_active`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; also strobes the serial key |
| rst_pin | input | 1 | Reset level and serial key input |
| addr_sel | input | 1 | 0: port carries low address byte, 1: high part |
| addr_port | input | 8 | Multiplexed address port |
| mode_verify | input | 1 | 1: verify, 0: program |
| wr_strobe | input | 1 | Program write strobe |
| data_in | input | 8 | Byte to program |
| data_out | output | 8 | Verified byte, 0 when not enabled |
| data_oe | output | 1 | Data port output enable |
| prog_active | output | 1 | Block is in the programming state |

## Verification
The reset takes effect on the RST_HOLD-th high edge. Programming state appears at the tenth key edge, which is eleven edges after the reset pin is released. The bench counts those edges exactly and also checks the state one edge early. Address and write updates land on the edge that samples them. Readback is combinational, so the bench drives inputs just after a rising edge and samples one time step later, well before the next edge.

// File: rtl/otp_prog_port.sv
module otp_prog_port #(
  parameter int          RST_HOLD = 24,
  parameter int          KEY_W    = 10,
  parameter logic [9:0]  KEY      = 10'h2D3,
  parameter int          LO_W     = 8,
  parameter int          HI_W     = 3,
  parameter int          DW       = 8
) (
  input  logic          clk,
  input  logic          rst_pin,
  input  logic          addr_sel,
  input  logic [LO_W-1:0] addr_port,
  input  logic          mode_verify,
  input  logic          wr_strobe,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic          prog_active
);
  localparam int AW    = LO_W + HI_W;
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(RST_HOLD + 1);
  localparam int BW    = $clog2(KEY_W);
  localparam logic [CW-1:0] HOLD_LAST = CW'(RST_HOLD - 1);
  localparam logic [CW-1:0] HOLD_MAX  = CW'(RST_HOLD);
  localparam logic [BW-1:0] BIT_LAST  = BW'(KEY_W - 1);

  typedef enum logic [1:0] {S_NORMAL, S_HELD, S_KEY, S_PROG} st_t;

  st_t              state;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    bitcnt;
  logic [KEY_W-1:0] shreg;
  logic [LO_W-1:0]  lo_q;
  logic [HI_W-1:0]  hi_q;
  logic [DW-1:0]    mem [DEPTH];
  logic             rst_now;
  logic [KEY_W-1:0] shnext;
  logic [AW-1:0]    addr;

  initial for (int i = 0; i < DEPTH; i++) mem[i] = '1;

  assign rst_now     = rst_pin && (cnt >= HOLD_LAST);
  assign shnext      = {rst_pin, shreg[KEY_W-1:1]};
  assign addr        = {hi_q, lo_q};
  assign prog_active = (state == S_PROG);
  assign data_oe     = prog_active && mode_verify;
  assign data_out    = data_oe ? mem[addr] : '0;

  always_ff @(posedge clk) begin
    if (!rst_pin)           cnt <= '0;
    else if (cnt != HOLD_MAX) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst_now) begin
      state  <= S_HELD;
      shreg  <= '0;
      bitcnt <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      case (state)
        S_HELD: if (!rst_pin) begin
          state  <= S_KEY;
          bitcnt <= '0;
          shreg  <= '0;
        end
        S_KEY: begin
          if (bitcnt == BIT_LAST) begin
            state <= (shnext == KEY) ? S_PROG : S_NORMAL;
            shreg <= '0;
          end else begin
            shreg  <= shnext;
            bitcnt <= bitcnt + 1'b1;
          end
        end
        S_PROG: begin
          if (addr_sel) hi_q <= addr_port[HI_W-1:0];
          else          lo_q <= addr_port;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (prog_active && !rst_now && !mode_verify && wr_strobe)
      mem[addr] <= mem[addr] & data_in;
  end
endmodule

// File: rtl/otp_prog_port_chk.sv
module otp_prog_port_chk #(
  parameter int RST_HOLD = 24
) (
  input logic        clk,
  input logic        rst_pin,
  input logic        prog_active,
  input logic        data_oe,
  input logic        mode_verify,
  input logic        addr_sel,
  input logic [7:0]  data_out,
  input logic [10:0] addr,
  input logic [2:0]  hi_q
);
  localparam int CW = $clog2(RST_HOLD + 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(RST_HOLD - 1);
  localparam logic [CW-1:0] HOLD_MAX  = CW'(RST_HOLD);

  logic [CW-1:0] hc = '0;
  logic seen = 1'b0;
  logic seen_d = 1'b0;
  logic hit;

  assign hit = rst_pin && (hc >= HOLD_LAST);

  always_ff @(posedge clk) begin
    if (!rst_pin)          hc <= '0;
    else if (hc != HOLD_MAX) hc <= hc + 1'b1;
    seen   <= seen | hit;
    seen_d <= seen;
  end

  a_r1_reset_clears: assert property (@(posedge clk) disable iff (!seen)
    hit |=> (!prog_active && !data_oe));

  a_r5_oe_needs_verify: assert property (@(posedge clk) disable iff (!seen)
    data_oe |-> (prog_active && mode_verify));

  a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (!seen)
    !data_oe |-> (data_out == 8'h00));

  a_r4_hi_holds_on_low_sel: assert property (@(posedge clk) disable iff (!seen_d)
    (prog_active && !addr_sel && !hit) |=> $stable(hi_q));

  a_r8_verify_read_stable: assert property (@(posedge clk) disable iff (!seen_d)
    (data_oe && $past(data_oe) && (addr == $past(addr))) |-> (data_out == $past(data_out)));
endmodule

bind otp_prog_port otp_prog_port_chk #(.RST_HOLD(RST_HOLD)) u_chk (
  .clk(clk), .rst_pin(rst_pin), .prog_active(prog_active), .data_oe(data_oe),
  .mode_verify(mode_verify), .addr_sel(addr_sel), .data_out(data_out),
  .addr(addr), .hi_q(hi_q)
);

// File: tb/test_otp_prog_port.sv
module test_otp_prog_port;
  localparam logic [9:0] KEY = 10'h2D3;

  logic       clk = 1'b0;
  logic       rst_pin = 1'b0;
  logic       addr_sel = 1'b0;
  logic [7:0] addr_port = '0;
  logic       mode_verify = 1'b1;
  logic       wr_strobe = 1'b0;
  logic [7:0] data_in = '0;
  logic [7:0] data_out;
  logic       data_oe;
  logic       prog_active;
  int vectors = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  otp_prog_port i_otp_prog_port (
    .clk(clk), .rst_pin(rst_pin), .addr_sel(addr_sel), .addr_port(addr_port),
    .mode_verify(mode_verify), .wr_strobe(wr_strobe), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .prog_active(prog_active)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(int n);
    rst_pin = 1'b1;
    for (int i = 0; i < n; i++) tick();
    rst_pin = 1'b0;
  endtask

  task automatic send_key(logic [9:0] k);
    tick();
    for (int i = 0; i < 10; i++) begin
      rst_pin = k[i];
      tick();
      if (i == 8) chk("R2 early", {7'b0, prog_active}, 8'h00);
    end
    rst_pin = 1'b0;
  endtask

  task automatic set_addr(logic [7:0] lo, logic [7:0] hi);
    addr_sel = 1'b0; addr_port = lo; tick();
    addr_sel = 1'b1; addr_port = hi; tick();
  endtask

  task automatic write_byte(logic [7:0] d);
    mode_verify = 1'b0; data_in = d; wr_strobe = 1'b1; tick();
    wr_strobe = 1'b0; mode_verify = 1'b1; #1;
  endtask

  task automatic t_reset();
    do_reset(24);
    chk("R1 prog_active", {7'b0, prog_active}, 8'h00);
    chk("R1 data_oe", {7'b0, data_oe}, 8'h00);
  endtask

  task automatic t_key_ok();
    do_reset(24);
    send_key(KEY);
    chk("R2 key accepted", {7'b0, prog_active}, 8'h01);
  endtask

  task automatic t_key_bad();
    do_reset(24);
    send_key(KEY ^ 10'h200);
    chk("R3 wrong key", {7'b0, prog_active}, 8'h00);
    send_key(KEY);
    chk("R3 no retry without reset", {7'b0, prog_active}, 8'h00);
  endtask

  task automatic t_erased_and_addr();
    t_key_ok();
    set_addr(8'hA5, 8'h05);
    chk("R7 erased", data_out, 8'hFF);
    chk("R5 oe", {7'b0, data_oe}, 8'h01);
    write_byte(8'h11);
    set_addr(8'hA5, 8'hFD);
    chk("R4 upper port bits ignored", data_out, 8'h11);
    set_addr(8'hA5, 8'h02);
    chk("R4 high part selects location", data_out, 8'hFF);
    write_byte(8'h22);
    chk("R5 readback", data_out, 8'h22);
    addr_sel = 1'b1; addr_port = 8'h05; tick();
    chk("R4 high-only reload", data_out, 8'h11);
  endtask

  task automatic t_program();
    set_addr(8'h3C, 8'h01);
    write_byte(8'hF0);
    chk("R7 first write", data_out, 8'hF0);
    write_byte(8'h3C);
    chk("R7 AND with old", data_out, 8'h30);
    write_byte(8'hFF);
    chk("R7 cannot set bits", data_out, 8'h30);
  endtask

  task automatic t_oe();
    mode_verify = 1'b0; #1;
    chk("R6 oe off in program mode", {7'b0, data_oe}, 8'h00);
    chk("R6 data zero", data_out, 8'h00);
    mode_verify = 1'b1; #1;
    chk("R5 oe back", {7'b0, data_oe}, 8'h01);
  endtask

  task automatic t_ignored();
    set_addr(8'h00, 8'h00);
    data_in = 8'h00; wr_strobe = 1'b1; tick(); wr_strobe = 1'b0;
    chk("R8 verify-mode strobe", data_out, 8'hFF);
    rst_pin = 1'b1;
    for (int i = 0; i < 23; i++) tick();
    rst_pin = 1'b0; tick();
    chk("R1 short pulse ignored", {7'b0, prog_active}, 8'h01);
    do_reset(24);
    send_key(KEY ^ 10'h001);
    mode_verify = 1'b0; data_in = 8'h00; wr_strobe = 1'b1; tick();
    wr_strobe = 1'b0; mode_verify = 1'b1;
    chk("R6 oe off outside prog", {7'b0, data_oe}, 8'h00);
    t_key_ok();
    #1;
    chk("R8 strobe outside prog state", data_out, 8'hFF);
    set_addr(8'h3C, 8'h01);
    chk("R1 memory survives reset", data_out, 8'h30);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    t_reset();
    t_key_bad();
    t_erased_and_addr();
    t_program();
    t_oe();
    t_ignored();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule